// File: doc/BRIEF.md
# Interrupt destination bitmask generator

This block turns the addressing fields of one interrupt message into the set of target processors that receive it. A sender presents an 8-bit destination, a physical/logical selector, a 2-bit shorthand, its own index and the delivery mode. Alongside these comes a per-target table that gives each target's presence, its 8-bit logical destination and its 4-bit format model. One clock after the request the block presents a bitmask with one bit per target, a flag for an empty result, and a flag that marks the message as an arbitration-ID synchronisation rather than an interrupt.

Logical addressing is resolved per target. A flat-model target matches on any common bit. A cluster-model target needs an equal upper nibble and a common bit in the lower nibble. The shorthand can replace the destination field with "self", "everyone" or "everyone but self". Lowest-priority delivery reduces the mask to the lowest-numbered target that remains. Arbitration by real priority and the transport of the message to the targets are left to neighbouring logic.

A small controller sequences the result. In state ST_IDLE no new result is announced. The transition T_ACCEPT (a request in ST_IDLE) enters ST_DONE and loads the result registers. T_CHAIN (a request in ST_DONE) stays in ST_DONE and reloads them. T_RETIRE (no request in ST_DONE) returns to ST_IDLE and keeps the last result on the outputs.

Top module: `ipi_dest_mask`

## Requirements
- R1: Shorthand code 1 selects only the target whose index equals the sender index, and only if that target is present.
- R2: Shorthand code 2 selects every present target, whatever the destination field holds.
- R3: Shorthand code 3 selects every present target except the sender.
- R4: With shorthand code 0 and physical mode (logical selector 0), destination 0xFF selects every present target. Any other value selects only the present target with that index, and an index at or above the target count selects none.
- R5: With shorthand code 0 and logical mode (selector 1), a present target with format model 0xF is selected when its logical destination shares a set bit with the destination.
- R6: With shorthand code 0 and logical mode, a present target with format model 0x0 is selected when bits 7:4 of the destination equal bits 7:4 of its logical destination and bits 3:0 of the two share a set bit.
- R7: In logical mode, a target whose format model is neither 0xF nor 0x0 is never selected.
- R8: A target whose presence bit is 0 never appears in the mask under any shorthand or mode.
- R9: For delivery mode 1 (lowest priority), only the lowest-numbered bit of the selected set is kept.
- R10: Delivery mode 5 with level bit 0 and trigger bit 1 raises sync_o, which marks the mask as the set of targets that copy their ID into their arbitration ID; any other combination leaves sync_o at 0.
- R11: none_o is 1 exactly when the resulting mask is all zeros.
- R12: A result appears on the outputs in the cycle after req_i is sampled high, with valid_o high for that cycle. Without a request the outputs keep their last value and valid_o falls. After reset the mask, none_o, sync_o and valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Sample the request fields this cycle |
| dest_i | input | 8 | Destination field |
| dest_logical_i | input | 1 | 0 physical, 1 logical addressing |
| shorthand_i | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| self_id_i | input | 8 | Index of the sending target |
| dmode_i | input | 3 | Delivery mode (1 lowest priority, 5 INIT) |
| level_i | input | 1 | Level bit of the message |
| trig_i | input | 1 | Trigger bit of the message |
| tgt_present_i | input | NTGT | Presence bit per target |
| tgt_ldest_i | input | NTGT*8 | Logical destination per target, target i at bits 8i+7:8i |
| tgt_model_i | input | NTGT*4 | Format model per target, target i at bits 4i+3:4i |
| valid_o | output | 1 | A new result is on the outputs this cycle |
| mask_o | output | NTGT | Selected targets, bit i is target i |
| none_o | output | 1 | Mask is empty |
| sync_o | output | 1 | Message is an arbitration-ID synchronisation |

## Verification
A wrong match term or a wrong shorthand decode shows up as a wrong or missing bit in mask_o in the single cycle after the request. The bench compares that full mask against a model built from the rules above, using a target table that mixes flat, cluster, unknown-model and absent entries. A controller that sits in the wrong state shows in valid_o one cycle after a request or a gap. A lost hold shows as mask_o changing during idle cycles. A broken reduction shows as more than one bit under lowest-priority delivery, visible in the same cycle as the result.

// File: rtl/ipi_dest_pkg.sv
package ipi_dest_pkg;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctl_state_e;

    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;
    localparam logic [2:0] DM_LOWEST     = 3'd1;
    localparam logic [2:0] DM_INIT       = 3'd5;
    localparam logic [7:0] PHYS_BCAST    = 8'hFF;

endpackage

// File: rtl/ipi_addr_match.sv
module ipi_addr_match
    import ipi_dest_pkg::*;
#(
    parameter int NTGT = 32
) (
    input  logic [7:0]        dest,
    input  logic              logical,
    input  logic [NTGT-1:0]   present,
    input  logic [NTGT*8-1:0] ldest,
    input  logic [NTGT*4-1:0] model,
    output logic [NTGT-1:0]   match
);

    genvar i;
    generate
        for (i = 0; i < NTGT; i++) begin : g_tgt
            logic [7:0] ld;
            logic [3:0] md;
            logic       flat_hit;
            logic       clus_hit;
            logic       phys_hit;

            assign ld = ldest[i*8 +: 8];
            assign md = model[i*4 +: 4];

            assign flat_hit = (md == MODEL_FLAT) && ((dest & ld) != 8'h00);
            assign clus_hit = (md == MODEL_CLUSTER) &&
                              (dest[7:4] == ld[7:4]) &&
                              ((dest[3:0] & ld[3:0]) != 4'h0);
            assign phys_hit = (dest == PHYS_BCAST) || (dest == 8'(i));

            assign match[i] = present[i] &
                              (logical ? (flat_hit | clus_hit) : phys_hit);
        end
    endgenerate

endmodule

// File: rtl/ipi_scope_sel.sv
module ipi_scope_sel
    import ipi_dest_pkg::*;
#(
    parameter int NTGT = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  shorthand_e      shorthand,
    input  logic [7:0]      self_id,
    input  logic [NTGT-1:0] match,
    input  logic [NTGT-1:0] present,
    output logic [NTGT-1:0] scoped
);

    logic [NTGT-1:0] self_onehot;

    genvar i;
    generate
        for (i = 0; i < NTGT; i++) begin : g_self
            assign self_onehot[i] = (self_id == 8'(i));
        end
    endgenerate

    always_comb begin
        unique case (shorthand)
            SH_FIELD:  scoped = match;
            SH_SELF:   scoped = present & self_onehot;
            SH_ALL:    scoped = present;
            SH_OTHERS: scoped = present & ~self_onehot;
            default:   scoped = '0;
        endcase
    end

    // R8: absent targets are never in the scoped set
    a_r8_absent_never: assert property (@(posedge clk) disable iff (!rst_n)
        (scoped & ~present) == '0);

    // R3: the sender is excluded under the all-but-self shorthand
    a_r3_excl_self: assert property (@(posedge clk) disable iff (!rst_n)
        (shorthand == SH_OTHERS) |-> ((scoped & self_onehot) == '0));

    // R1: the self shorthand selects at most one target
    a_r1_self_single: assert property (@(posedge clk) disable iff (!rst_n)
        (shorthand == SH_SELF) |-> $onehot0(scoped));

endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
    parameter int NTGT = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [NTGT-1:0] in_mask,
    output logic [NTGT-1:0] out_mask
);

    logic [NTGT:0]   seen;
    logic [NTGT-1:0] first;

    assign seen[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < NTGT; i++) begin : g_chain
            assign first[i]  = in_mask[i] & ~seen[i];
            assign seen[i+1] = seen[i] | in_mask[i];
        end
    endgenerate

    assign out_mask = enable ? first : in_mask;

    // R9: the reduced mask is a single bit taken from the input set
    a_r9_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> ($onehot0(out_mask) && ((out_mask & ~in_mask) == '0)));

    // R9: reduction keeps a bit whenever the input had one
    a_r9_keeps_one: assert property (@(posedge clk) disable iff (!rst_n)
        enable && (in_mask != '0) |-> (out_mask != '0));

endmodule

// File: rtl/ipi_dest_mask.sv
module ipi_dest_mask
    import ipi_dest_pkg::*;
#(
    parameter int NTGT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [7:0]        dest_i,
    input  logic              dest_logical_i,
    input  logic [1:0]        shorthand_i,
    input  logic [7:0]        self_id_i,
    input  logic [2:0]        dmode_i,
    input  logic              level_i,
    input  logic              trig_i,
    input  logic [NTGT-1:0]   tgt_present_i,
    input  logic [NTGT*8-1:0] tgt_ldest_i,
    input  logic [NTGT*4-1:0] tgt_model_i,
    output logic              valid_o,
    output logic [NTGT-1:0]   mask_o,
    output logic              none_o,
    output logic              sync_o
);

    localparam int MAX_TGT = 256;

    initial begin
        if (NTGT < 1 || NTGT > MAX_TGT)
            $error("NTGT out of range");
    end

    ctl_state_e      state_q, state_d;
    logic [NTGT-1:0] match_c;
    logic [NTGT-1:0] scoped_c;
    logic [NTGT-1:0] final_c;
    logic            lowest_c;
    logic            deassert_c;
    logic            lowest_q;
    logic [NTGT-1:0] mask_q;
    logic            none_q;
    logic            sync_q;

    assign lowest_c   = (dmode_i == DM_LOWEST);
    assign deassert_c = (dmode_i == DM_INIT) && !level_i && trig_i;

    ipi_addr_match #(.NTGT(NTGT)) u_match (
        .dest    (dest_i),
        .logical (dest_logical_i),
        .present (tgt_present_i),
        .ldest   (tgt_ldest_i),
        .model   (tgt_model_i),
        .match   (match_c)
    );

    ipi_scope_sel #(.NTGT(NTGT)) u_scope (
        .clk       (clk),
        .rst_n     (rst_n),
        .shorthand (shorthand_e'(shorthand_i)),
        .self_id   (self_id_i),
        .match     (match_c),
        .present   (tgt_present_i),
        .scoped    (scoped_c)
    );

    ipi_lowest_pick #(.NTGT(NTGT)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (lowest_c),
        .in_mask  (scoped_c),
        .out_mask (final_c)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_i) state_d = ST_DONE;   // T_ACCEPT
            ST_DONE: if (!req_i) state_d = ST_IDLE;  // T_RETIRE, else T_CHAIN
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            none_q   <= 1'b0;
            sync_q   <= 1'b0;
            lowest_q <= 1'b0;
        end else if (req_i) begin
            mask_q   <= final_c;
            none_q   <= (final_c == '0);
            sync_q   <= deassert_c;
            lowest_q <= lowest_c;
        end
    end

    assign valid_o = (state_q == ST_DONE);
    assign mask_o  = mask_q;
    assign none_o  = none_q;
    assign sync_o  = sync_q;

    // R12: a request is answered in the next cycle
    a_r12_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    // R12: the result holds while no request arrives
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!valid_o && $stable(mask_o) && $stable(none_o) && $stable(sync_o)));

    // R11: empty flag agrees with the presented mask
    a_r11_none_flag: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (none_o == (mask_o == '0)));

    // R9: a lowest-priority result carries at most one target
    a_r9_out_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && lowest_q) |-> $onehot0(mask_o));

endmodule

// File: tb/sim_ipi_dest_mask.sv
module sim_ipi_dest_mask;

    localparam int NT = 32;
    localparam int NV = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_i = 1'b0;
    logic [7:0]      dest_i = 8'h00;
    logic            dest_logical_i = 1'b0;
    logic [1:0]      shorthand_i = 2'd0;
    logic [7:0]      self_id_i = 8'h00;
    logic [2:0]      dmode_i = 3'd0;
    logic            level_i = 1'b0;
    logic            trig_i = 1'b0;
    logic [NT-1:0]   pres;
    logic [NT*8-1:0] ldest;
    logic [NT*4-1:0] model;
    logic            valid_o;
    logic [NT-1:0]   mask_o;
    logic            none_o;
    logic            sync_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ipi_dest_mask #(.NTGT(NT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .dest_i(dest_i),
        .dest_logical_i(dest_logical_i), .shorthand_i(shorthand_i),
        .self_id_i(self_id_i), .dmode_i(dmode_i), .level_i(level_i),
        .trig_i(trig_i), .tgt_present_i(pres), .tgt_ldest_i(ldest),
        .tgt_model_i(model), .valid_o(valid_o), .mask_o(mask_o),
        .none_o(none_o), .sync_o(sync_o)
    );

    // stimulus table: dest, logical, shorthand, self, dmode, level, trig
    localparam logic [23:0] VEC [NV] = '{
        {8'h05, 1'b0, 2'd0, 8'd0,  3'd0, 1'b0, 1'b0},
        {8'hFF, 1'b0, 2'd0, 8'd0,  3'd0, 1'b0, 1'b0},
        {8'h13, 1'b1, 2'd0, 8'd0,  3'd0, 1'b0, 1'b0},
        {8'h3F, 1'b1, 2'd0, 8'd0,  3'd0, 1'b0, 1'b0},
        {8'h1A, 1'b1, 2'd0, 8'd0,  3'd1, 1'b0, 1'b0},
        {8'h00, 1'b0, 2'd1, 8'd12, 3'd0, 1'b0, 1'b0},
        {8'h44, 1'b1, 2'd2, 8'd3,  3'd0, 1'b0, 1'b0},
        {8'h00, 1'b0, 2'd3, 8'd31, 3'd0, 1'b0, 1'b0},
        {8'h20, 1'b1, 2'd3, 8'd22, 3'd1, 1'b0, 1'b0},
        {8'hFF, 1'b0, 2'd0, 8'd0,  3'd1, 1'b0, 1'b0},
        {8'h00, 1'b0, 2'd2, 8'd0,  3'd5, 1'b0, 1'b1},
        {8'h80, 1'b1, 2'd0, 8'd0,  3'd5, 1'b1, 1'b1}
    };

    function automatic logic [NT-1:0] ref_mask(
        input logic [7:0] d, input logic lg, input logic [1:0] sh,
        input logic [7:0] sf, input logic [2:0] dm);
        logic [NT-1:0] m;
        m = '0;
        for (int i = 0; i < NT; i++) begin
            logic [7:0] ld;
            logic [3:0] md;
            logic hit;
            ld = ldest[i*8 +: 8];
            md = model[i*4 +: 4];
            hit = 1'b0;
            case (sh)
                2'd1: hit = (int'(sf) == i);
                2'd2: hit = 1'b1;
                2'd3: hit = (int'(sf) != i);
                default: begin
                    if (!lg) hit = (d == 8'hFF) || (int'(d) == i);
                    else if (md == 4'hF) hit = (d & ld) != 0;
                    else if (md == 4'h0) hit = (d[7:4] == ld[7:4]) && ((d[3:0] & ld[3:0]) != 0);
                end
            endcase
            m[i] = hit && pres[i];
        end
        if (dm == 3'd1) begin
            logic found;
            found = 1'b0;
            for (int i = 0; i < NT; i++) begin
                if (m[i] && !found) found = 1'b1;
                else m[i] = 1'b0;
            end
        end
        return m;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [23:0] v);
        @(negedge clk);
        {dest_i, dest_logical_i, shorthand_i, self_id_i, dmode_i, level_i, trig_i} = v;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NT; i++) begin
            pres[i] = !(i == 7 || i == 20);
            if (i < 16) begin
                ldest[i*8 +: 8] = 8'(1 << (i % 8));
                model[i*4 +: 4] = 4'hF;
            end else if (i < 28) begin
                ldest[i*8 +: 8] = {4'((i - 16) / 4 + 1), 4'(1 << ((i - 16) % 4))};
                model[i*4 +: 4] = 4'h0;
            end else begin
                ldest[i*8 +: 8] = 8'hFF;
                model[i*4 +: 4] = 4'h5;
            end
        end
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 reset valid", 64'(valid_o), 64'd0);
        check("R12 reset mask", 64'(mask_o), 64'd0);
        check("R12 reset none/sync", 64'({none_o, sync_o}), 64'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            logic [NT-1:0] e;
            e = ref_mask(VEC[k][23:16], VEC[k][15], VEC[k][14:13], VEC[k][12:5], VEC[k][4:2]);
            issue(VEC[k]);
            check($sformatf("R12 vec%0d valid", k), 64'(valid_o), 64'd1);
            check($sformatf("R1-style table vec%0d mask R4 R5 R6 R9", k), 64'(mask_o), 64'(e));
            check($sformatf("R11 vec%0d none", k), 64'(none_o), 64'(e == '0));
            check($sformatf("R10 vec%0d sync", k), 64'(sync_o),
                  64'(VEC[k][4:2] == 3'd5 && !VEC[k][1] && VEC[k][0]));
        end

        // directed, hand-worked expected values
        issue({8'h05, 1'b0, 2'd0, 8'd0, 3'd0, 1'b0, 1'b0});
        check("R4 physical index 5", 64'(mask_o), 64'h20);
        issue({8'h07, 1'b0, 2'd0, 8'd0, 3'd0, 1'b0, 1'b0});
        check("R8 physical absent 7", 64'(mask_o), 64'h0);
        check("R11 none on absent", 64'(none_o), 64'd1);
        issue({8'hFF, 1'b0, 2'd0, 8'd0, 3'd0, 1'b0, 1'b0});
        check("R4 physical broadcast", 64'(mask_o), 64'hFFEFFF7F);
        issue({8'd40, 1'b0, 2'd0, 8'd0, 3'd0, 1'b0, 1'b0});
        check("R4 index beyond count", 64'(mask_o), 64'h0);
        issue({8'h03, 1'b1, 2'd0, 8'd0, 3'd0, 1'b0, 1'b0});
        check("R5 flat logical 0x03", 64'(mask_o), 64'h303);
        issue({8'h25, 1'b1, 2'd0, 8'd0, 3'd0, 1'b0, 1'b0});
        check("R6 cluster plus flat 0x25", 64'(mask_o), 64'h00402525);
        issue({8'h3F, 1'b1, 2'd0, 8'd0, 3'd0, 1'b0, 1'b0});
        check("R7 unknown model never hit", 64'(mask_o[31:28]), 64'h0);
        issue({8'h25, 1'b1, 2'd0, 8'd0, 3'd1, 1'b0, 1'b0});
        check("R9 lowest of 0x25 set", 64'(mask_o), 64'h1);
        issue({8'h00, 1'b0, 2'd1, 8'd9, 3'd0, 1'b0, 1'b0});
        check("R1 self 9", 64'(mask_o), 64'h200);
        issue({8'h00, 1'b0, 2'd1, 8'd7, 3'd0, 1'b0, 1'b0});
        check("R1 R8 self absent", 64'(mask_o), 64'h0);
        issue({8'h05, 1'b0, 2'd2, 8'd0, 3'd0, 1'b0, 1'b0});
        check("R2 all ignores field", 64'(mask_o), 64'hFFEFFF7F);
        issue({8'h00, 1'b0, 2'd3, 8'd0, 3'd1, 1'b0, 1'b0});
        check("R3 R9 others lowest", 64'(mask_o), 64'h2);
        issue({8'h00, 1'b0, 2'd3, 8'd5, 3'd0, 1'b0, 1'b0});
        check("R3 others excludes 5", 64'(mask_o), 64'hFFEFFF5F);
        issue({8'h00, 1'b0, 2'd2, 8'd0, 3'd5, 1'b0, 1'b1});
        check("R10 deassert sync", 64'(sync_o), 64'd1);
        check("R10 deassert targets", 64'(mask_o), 64'hFFEFFF7F);
        issue({8'h00, 1'b0, 2'd2, 8'd0, 3'd5, 1'b1, 1'b1});
        check("R10 asserted init no sync", 64'(sync_o), 64'd0);

        // R12 hold while idle
        @(negedge clk);
        dest_i = 8'h01;
        shorthand_i = 2'd0;
        dmode_i = 3'd0;
        @(negedge clk);
        check("R12 idle valid low", 64'(valid_o), 64'd0);
        check("R12 idle mask held", 64'(mask_o), 64'hFFEFFF7F);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule